// File: doc/BRIEF.md
# Multiplexed-Bus Burst Read Target

This block answers read bursts on a parallel shared bus whose control lines are active low. One 32-bit path carries the address in the first clock of a transaction and data words in later clocks. A four-line group carries the bus command in that first clock and byte enables in later clocks. The block watches for the clock in which the initiator first pulls the frame line low. In that clock it takes the address and the command. If the command is a memory read and the address falls inside a fixed window, the block claims the transaction by pulling its device-select output low.

After one turnaround clock the block drives words from a small local register array onto the shared path. It reads that array through a simple index/strobe port. A word moves only in a clock where both initiator-ready and target-ready are low. The word index then steps to the next entry and wraps at the end of the array. When the initiator completes a transfer with frame already released, that transfer is the last one. The block then releases target-ready and device-select and stops driving the path. The shared path is split into an input, an output and an output enable, so a pad ring or a bus model can join them.

Top module: `mbt_burst_target`

## Requirements
- R1: While reset is low, and after reset until a transaction is claimed, devsel_n and trdy_n are high and ad_oe is low.
- R2: A transaction is claimed when all of the following hold in the clock where frame_n is first low (it was high in the clock before): cbe_n equals 4'b0110 (memory read), ad_in lies within [BASE_ADDR, BASE_ADDR + 2^WIN_LOG2), and ad_in[1:0] is 2'b00. devsel_n then goes low in the next clock and stays low until the transaction ends.
- R3: In the clock right after the address clock, devsel_n is low while trdy_n stays high and ad_oe stays low. Both trdy_n low and ad_oe high appear one clock later.
- R4: The first word driven is the array entry indexed by ad_in[WIN_LOG2-1:2] of the address clock. In the turnaround clock, loc_rd is high and loc_idx carries that index.
- R5: ad_out steps to the next entry only after a clock in which both irdy_n and trdy_n are low. A clock with irdy_n high leaves ad_out unchanged and keeps loc_rd low.
- R6: A transfer made while frame_n is high is the last one. In the next clock devsel_n and trdy_n are high and ad_oe is low.
- R7: An address outside the window draws no response: devsel_n, trdy_n and ad_oe keep their idle values.
- R8: Any command other than 4'b0110 draws no response, even if the address is in the window.
- R9: The values on cbe_n during data clocks have no effect on the words returned.
- R10: The entry index wraps from the last array entry (2^(WIN_LOG2-2) - 1) to entry 0 within a burst.
- R11: Only a falling frame_n starts decoding. If frame_n stays low after an ignored start, a later in-window memory-read address on ad_in is not claimed.
- R12: A new transaction whose address clock directly follows the final transfer of the previous one is decoded and claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Transaction frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | BUS_W/8 | Command in the address clock, byte enables afterwards |
| ad_in | input | BUS_W | Shared address/data path as seen by the block |
| ad_out | output | BUS_W | Read data the block drives onto the shared path |
| ad_oe | output | 1 | High while the block drives the shared path |
| trdy_n | output | 1 | Target ready, active low |
| devsel_n | output | 1 | Device-select response, active low |
| loc_rd | output | 1 | Local array read strobe |
| loc_idx | output | WIN_LOG2-2 | Local array entry index |
| loc_rdata | input | BUS_W | Local array word for loc_idx, same clock |

## Verification
The bound checker watches the handshake shape on every cycle. Target-ready never appears without device-select. The output enable tracks target-ready. A claim is always followed by a turnaround clock in which the array is fetched. A waited clock holds the data and fetches nothing. A final transfer always releases the bus. Which transactions get claimed, which word is returned, byte-enable independence, index wrap and the refusal to re-decode a held-low frame depend on the address and command values. Only the bench's scenarios, with their expected words and responses, can show those.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_DATA = 2'd2
    } mbt_state_e;

    // bus command code that this target answers
    localparam logic [3:0] CMD_MEM_READ = 4'b0110;

endpackage

// File: rtl/mbt_addr_decode.sv
module mbt_addr_decode
    import mbt_pkg::*;
#(
    parameter int               BUS_W     = 32,
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'h4000_0000,
    parameter int               WIN_LOG2  = 6,
    localparam int              IDX_W     = WIN_LOG2 - 2
) (
    input  logic [BUS_W-1:0] addr,
    input  logic [3:0]       cmd_n,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic in_window;
    logic linear;
    logic is_read;

    always_comb begin
        in_window = (addr[BUS_W-1:WIN_LOG2] == BASE_ADDR[BUS_W-1:WIN_LOG2]);
        linear    = (addr[1:0] == 2'b00);
        is_read   = (cmd_n == CMD_MEM_READ);
        hit       = in_window && linear && is_read;
        idx       = addr[WIN_LOG2-1:2];
    end

endmodule

// File: rtl/mbt_word_ptr.sv
module mbt_word_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             step,
    output logic [IDX_W-1:0] idx_q,
    output logic [IDX_W-1:0] idx_inc
);

    logic [IDX_W-1:0] idx_d;

    always_comb begin
        // array depth is a power of two, so the carry out is dropped to wrap
        idx_inc = idx_q + 1'b1;
        idx_d   = idx_q;
        if (load) begin
            idx_d = load_idx;
        end else if (step) begin
            idx_d = idx_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

endmodule

// File: rtl/mbt_burst_target.sv
module mbt_burst_target
    import mbt_pkg::*;
#(
    parameter int               BUS_W     = 32,
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'h4000_0000,
    parameter int               WIN_LOG2  = 6,
    localparam int              IDX_W     = WIN_LOG2 - 2,
    localparam int              BE_W      = BUS_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [BE_W-1:0]  cbe_n,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    output logic             trdy_n,
    output logic             devsel_n,
    output logic             loc_rd,
    output logic [IDX_W-1:0] loc_idx,
    input  logic [BUS_W-1:0] loc_rdata
);

    typedef struct packed {
        mbt_state_e       st;
        logic             frame_n;
        logic             devsel_n;
        logic             trdy_n;
        logic             oe;
        logic [BUS_W-1:0] ad;
    } regs_t;

    regs_t r_d, r_q;

    logic             hit;
    logic [IDX_W-1:0] dec_idx;
    logic             start;
    logic             xfer;
    logic             ptr_load;
    logic             ptr_step;
    logic [IDX_W-1:0] ptr_idx;
    logic [IDX_W-1:0] ptr_inc;

    mbt_addr_decode #(
        .BUS_W     (BUS_W),
        .BASE_ADDR (BASE_ADDR),
        .WIN_LOG2  (WIN_LOG2)
    ) u_decode (
        .addr  (ad_in),
        .cmd_n (cbe_n[3:0]),
        .hit   (hit),
        .idx   (dec_idx)
    );

    mbt_word_ptr #(
        .IDX_W (IDX_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_idx (dec_idx),
        .step     (ptr_step),
        .idx_q    (ptr_idx),
        .idx_inc  (ptr_inc)
    );

    always_comb begin
        r_d         = r_q;
        r_d.frame_n = frame_n;
        start       = !frame_n && r_q.frame_n;
        xfer        = !irdy_n && !r_q.trdy_n;
        ptr_load    = 1'b0;
        ptr_step    = 1'b0;
        loc_rd      = 1'b0;
        loc_idx     = ptr_idx;

        case (r_q.st)
            ST_IDLE: begin
                if (start && hit) begin
                    r_d.st       = ST_TURN;
                    r_d.devsel_n = 1'b0;
                    ptr_load     = 1'b1;
                end
            end
            ST_TURN: begin
                // path is left undriven this clock; fetch the first word
                r_d.st     = ST_DATA;
                r_d.trdy_n = 1'b0;
                r_d.oe     = 1'b1;
                r_d.ad     = loc_rdata;
                loc_rd     = 1'b1;
            end
            ST_DATA: begin
                loc_idx = ptr_inc;
                if (xfer) begin
                    if (frame_n) begin
                        r_d.st       = ST_IDLE;
                        r_d.devsel_n = 1'b1;
                        r_d.trdy_n   = 1'b1;
                        r_d.oe       = 1'b0;
                    end else begin
                        r_d.ad   = loc_rdata;
                        loc_rd   = 1'b1;
                        ptr_step = 1'b1;
                    end
                end
            end
            default: begin
                r_d.st       = ST_IDLE;
                r_d.devsel_n = 1'b1;
                r_d.trdy_n   = 1'b1;
                r_d.oe       = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, frame_n: 1'b1, devsel_n: 1'b1,
                     trdy_n: 1'b1, oe: 1'b0, ad: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ad_out   = r_q.ad;
    assign ad_oe    = r_q.oe;
    assign trdy_n   = r_q.trdy_n;
    assign devsel_n = r_q.devsel_n;

endmodule

// File: rtl/mbt_burst_target_chk.sv
module mbt_burst_target_chk #(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_n,
    input logic             irdy_n,
    input logic [BUS_W-1:0] ad_out,
    input logic             ad_oe,
    input logic             trdy_n,
    input logic             devsel_n,
    input logic             loc_rd
);

    AST_TRDY_NEEDS_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n); // R2

    AST_CLAIM_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> $past(!frame_n)); // R2

    AST_IDLE_BUS_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_n && devsel_n) |=> devsel_n); // R11

    AST_TURN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> (trdy_n && !ad_oe)); // R3

    AST_OE_MATCHES_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe == !trdy_n); // R3

    AST_FETCH_ON_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> loc_rd); // R4

    AST_WAIT_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> $stable(ad_out)); // R5

    AST_WAIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |-> !loc_rd); // R5

    AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe)); // R6

endmodule

bind mbt_burst_target mbt_burst_target_chk #(.BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .trdy_n   (trdy_n),
    .devsel_n (devsel_n),
    .loc_rd   (loc_rd)
);

// File: tb/mbt_burst_target_tb_top.sv
`timescale 1ns/1ps
module mbt_burst_target_tb_top;

    localparam int          BUS_W = 32;
    localparam logic [31:0] BASE  = 32'h4000_0000;
    localparam int          WIN   = 6;
    localparam int          IW    = WIN - 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_n = 1'b1;
    logic             irdy_n = 1'b1;
    logic [3:0]       cbe_n = 4'hF;
    logic [BUS_W-1:0] ad_in = '0;
    logic [BUS_W-1:0] ad_out;
    logic             ad_oe;
    logic             trdy_n;
    logic             devsel_n;
    logic             loc_rd;
    logic [IW-1:0]    loc_idx;
    logic [BUS_W-1:0] loc_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] word_of(input logic [IW-1:0] i);
        return 32'hC0DE_0000 + 32'(i) * 32'h111;
    endfunction

    // local register array model
    assign loc_rdata = word_of(loc_idx);

    mbt_burst_target #(
        .BUS_W (BUS_W), .BASE_ADDR (BASE), .WIN_LOG2 (WIN)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .frame_n (frame_n), .irdy_n (irdy_n),
        .cbe_n (cbe_n), .ad_in (ad_in), .ad_out (ad_out), .ad_oe (ad_oe),
        .trdy_n (trdy_n), .devsel_n (devsel_n), .loc_rd (loc_rd),
        .loc_idx (loc_idx), .loc_rdata (loc_rdata)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [2:0] bus_resp();
        return {devsel_n, trdy_n, ad_oe};
    endfunction

    // per row: outputs expected now, then inputs to apply for this clock
    typedef struct packed {
        logic        fr;
        logic        ir;
        logic [3:0]  cbe;
        logic [31:0] ad;
        logic [2:0]  e_resp;   // {devsel_n, trdy_n, ad_oe}
        logic        chk_d;
        logic [3:0]  e_idx;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        // R2/R4/R5/R6: four words from index 2 with one wait clock
        '{1'b0, 1'b1, 4'h6, 32'h4000_0008, 3'b110, 1'b0, 4'd0,  4'd1},
        '{1'b0, 1'b0, 4'h0, 32'h0,         3'b010, 1'b0, 4'd0,  4'd3},
        '{1'b0, 1'b0, 4'h0, 32'h0,         3'b001, 1'b1, 4'd2,  4'd4},
        '{1'b0, 1'b1, 4'h0, 32'h0,         3'b001, 1'b1, 4'd3,  4'd5},
        '{1'b0, 1'b0, 4'h0, 32'h0,         3'b001, 1'b1, 4'd3,  4'd5},
        '{1'b0, 1'b0, 4'h0, 32'h0,         3'b001, 1'b1, 4'd4,  4'd5},
        '{1'b1, 1'b0, 4'h0, 32'h0,         3'b001, 1'b1, 4'd5,  4'd5},
        // R12: next address clock follows the last transfer directly
        '{1'b0, 1'b1, 4'h6, 32'h4000_003C, 3'b110, 1'b0, 4'd0,  4'd6},
        // R9: byte enables all disabled / mixed; R10: 15 wraps to 0
        '{1'b0, 1'b0, 4'hF, 32'h0,         3'b010, 1'b0, 4'd0,  4'd12},
        '{1'b0, 1'b0, 4'hF, 32'h0,         3'b001, 1'b1, 4'd15, 4'd9},
        '{1'b1, 1'b0, 4'h5, 32'h0,         3'b001, 1'b1, 4'd0,  4'd10},
        '{1'b1, 1'b1, 4'hF, 32'h0,         3'b110, 1'b0, 4'd0,  4'd6},
        // R7: just above the window; R11: frame kept low, valid address later
        '{1'b0, 1'b1, 4'h6, 32'h4000_0040, 3'b110, 1'b0, 4'd0,  4'd1},
        '{1'b0, 1'b0, 4'h6, 32'h4000_0004, 3'b110, 1'b0, 4'd0,  4'd7},
        '{1'b1, 1'b0, 4'h0, 32'h0,         3'b110, 1'b0, 4'd0,  4'd11},
        '{1'b1, 1'b1, 4'hF, 32'h0,         3'b110, 1'b0, 4'd0,  4'd11},
        // R8: memory-write command in the window
        '{1'b0, 1'b1, 4'h7, 32'h4000_0004, 3'b110, 1'b0, 4'd0,  4'd1},
        '{1'b0, 1'b0, 4'h0, 32'h0,         3'b110, 1'b0, 4'd0,  4'd8},
        '{1'b1, 1'b0, 4'h0, 32'h0,         3'b110, 1'b0, 4'd0,  4'd8},
        // R7: just below the window
        '{1'b1, 1'b1, 4'hF, 32'h0,         3'b110, 1'b0, 4'd0,  4'd8},
        '{1'b0, 1'b1, 4'h6, 32'h3FFF_FFFC, 3'b110, 1'b0, 4'd0,  4'd1},
        '{1'b1, 1'b0, 4'h0, 32'h0,         3'b110, 1'b0, 4'd0,  4'd7},
        // R4/R6: single-word read from index 4
        '{1'b0, 1'b1, 4'h6, 32'h4000_0010, 3'b110, 1'b0, 4'd0,  4'd7},
        '{1'b1, 1'b0, 4'h0, 32'h0,         3'b010, 1'b0, 4'd0,  4'd3},
        '{1'b1, 1'b0, 4'h0, 32'h0,         3'b001, 1'b1, 4'd4,  4'd4},
        '{1'b1, 1'b1, 4'hF, 32'h0,         3'b110, 1'b0, 4'd0,  4'd6}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle while reset is held
        check(bus_resp() == 3'b110, "R1", 32'(bus_resp()), 32'(3'b110));
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check(bus_resp() == VECS[i].e_resp, $sformatf("R%0d resp row %0d", VECS[i].rq, i),
                  32'(bus_resp()), 32'(VECS[i].e_resp));
            if (VECS[i].chk_d) begin
                check(ad_out == word_of(VECS[i].e_idx),
                      $sformatf("R%0d data row %0d", VECS[i].rq, i),
                      ad_out, word_of(VECS[i].e_idx));
            end
            frame_n = VECS[i].fr;
            irdy_n  = VECS[i].ir;
            cbe_n   = VECS[i].cbe;
            ad_in   = VECS[i].ad;
        end

        // R4: local port in the turnaround clock, then R1: reset mid-burst
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'h6; ad_in = BASE + 32'h20;
        @(negedge clk);
        check(loc_rd == 1'b1 && loc_idx == 4'd8, "R4 loc port",
              {27'd0, loc_rd, loc_idx}, {27'd0, 1'b1, 4'd8});
        frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'h0; ad_in = '0;
        @(negedge clk);
        check(ad_out == word_of(4'd8), "R4 first word", ad_out, word_of(4'd8));
        rst_n = 1'b0;
        #1;
        check(bus_resp() == 3'b110, "R1 reset mid-burst", 32'(bus_resp()), 32'(3'b110));
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_resp() == 3'b110, "R1 after release", 32'(bus_resp()), 32'(3'b110));

        summary();
        $finish;
    end

endmodule